// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and gives a product of `2*WIDTH` bits. It uses a single `WIDTH`-bit adder and a small sequencer, so it trades latency for area. A pulse on the start input, given while the block is idle, captures both operands. The multiplicand goes into a holding register. The multiplier goes into the low half of a combined accumulator/multiplier register, and the upper half is cleared.

Each clock while running performs one whole iteration in a single register update. When the low bit of the multiplier register is set, the multiplicand is added into the accumulator; otherwise zero is added. The adder's carry-out and sum are then moved right by one place together with the multiplier register. The carry becomes the accumulator MSB, and the accumulator LSB enters the multiplier MSB. After exactly `WIDTH` iterations the accumulator holds the upper half of the product and the multiplier register holds the lower half. A one-cycle completion pulse marks the end of the run. The product output then holds its value until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: A start accepted while idle raises `busy_o` at the next clock edge. At that edge `product_o` becomes {`WIDTH` zeros, multiplier}, and the multiplicand is captured.
- R3: `busy_o` stays high for exactly `WIDTH` clock cycles. At the edge where it falls, `done_o` goes high, and `done_o` is high for exactly one cycle.
- R4: When `done_o` is high, `product_o` equals the unsigned product multiplicand × multiplier, with the accumulator in bits [2*WIDTH-1:WIDTH] and the multiplier register in bits [WIDTH-1:0].
- R5: In an iteration whose multiplier-register LSB is 0, nothing is added, and the accumulator only shifts right. In an iteration whose LSB is 1, the adder carry-out enters the accumulator MSB, so all-ones operands give (2^WIDTH-1)^2.
- R6: A start pulse, or a change of operands, while `busy_o` is high is ignored and does not alter the running product.
- R7: While idle and with no start, `product_o` holds its last value, whatever the operand inputs do.
- R8: For multiplicand 13 and multiplier 11 the product is 143.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiply; taken only when idle |
| mcand_i | input | WIDTH | Multiplicand operand |
| mplier_i | input | WIDTH | Multiplier operand |
| busy_o | output | 1 | High while iterations are running |
| done_o | output | 1 | One-cycle pulse when the product is complete |
| product_o | output | 2*WIDTH | Combined accumulator and multiplier registers |

## Verification
The assertions watch, on every cycle, several properties of the block. The completion pulse must last one cycle and come only after exactly `WIDTH` counted iterations. A no-add iteration must be a plain right shift of the accumulator. A load must clear the accumulator and capture the multiplier. The multiplicand register must stay untouched while running, and the idle product must hold. These properties cannot show that the add-with-carry path forms the correct full product. That is shown only by the bench's scenarios. They compare each result against a column-sum reference for random operands, for zero and all-ones operands, and for the 13 × 11 case. They also cover runs where a second start and new operands arrive mid-run.

// File: rtl/shm_pkg.sv
package shm_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/shm_adder.sv
module shm_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic             add_en_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  logic [WIDTH-1:0] operand;

  // Two-way choice per bit between the multiplicand and zero.
  for (genvar i = 0; i < WIDTH; i++) begin : g_gate
    assign operand[i] = add_en_i & mcand_i[i];
  end

  assign {carry_o, sum_o} = {1'b0, acc_i} + {1'b0, operand};

endmodule

// File: rtl/shm_sequencer.sv
module shm_sequencer
  import shm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last_step;

  assign load_o    = start_i && (state_q == SEQ_IDLE);
  assign step_o    = (state_q == SEQ_RUN);
  assign last_step = step_o && (cnt_q == LAST);
  assign busy_o    = step_o;
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_step;
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
          end
        end
        SEQ_RUN: begin
          if (cnt_q == LAST) state_q <= SEQ_IDLE;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // Independent count of iterations in the current run, for checking.
  logic [CNT_W:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (load_o) run_len <= '0;
    else if (step_o) run_len <= run_len + 1'b1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_DONE_AFTER_N: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_len == (CNT_W+1)'(WIDTH)) && !busy_o); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !last_step) |=> busy_o && !done_o); // R6

endmodule

// File: rtl/shm_datapath.sv
module shm_datapath #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] product_o
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] m_q;
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] step_sum;
  logic             step_carry;
  logic             add_en;
  logic [PW-1:0]    shifted;

  // Carry, sum and multiplier register move right as one word.
  function automatic logic [PW-1:0] shift_joined(
    input logic             c,
    input logic [WIDTH-1:0] s,
    input logic [WIDTH-1:0] q
  );
    logic [PW:0] t;
    t = {c, s, q};
    return t[PW:1];
  endfunction

  assign add_en  = q_q[0];
  assign shifted = shift_joined(step_carry, step_sum, q_q);

  shm_adder #(.WIDTH(WIDTH)) u_adder (
    .acc_i   (a_q),
    .mcand_i (m_q),
    .add_en_i(add_en),
    .sum_o   (step_sum),
    .carry_o (step_carry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      a_q <= '0;
      q_q <= '0;
    end else if (load_i) begin
      m_q <= mcand_i;
      a_q <= '0;
      q_q <= mplier_i;
    end else if (step_i) begin
      a_q <= shifted[PW-1:WIDTH];
      q_q <= shifted[WIDTH-1:0];
    end
  end

  assign product_o = {a_q, q_q};

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (a_q == '0) && (q_q == $past(mplier_i)) && (m_q == $past(mcand_i))); // R2
  AST_NOADD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !q_q[0]) |=> a_q == ($past(a_q) >> 1)); // R5
  AST_MCAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> $stable(m_q)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(product_o)); // R7

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);

  logic load;
  logic step;

  shm_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  shm_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .product_o(product_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R3

endmodule

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;

  localparam int W        = 8;
  localparam int CLK_PER  = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic [W-1:0]   mcand_i = '0;
  logic [W-1:0]   mplier_i = '0;
  logic           busy_o;
  logic           done_o;
  logic [2*W-1:0] product_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PER/2) clk = ~clk;

  shift_add_mul #(.WIDTH(W)) u_shift_add_mul (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
  );

  // Reference: sum of the multiplicand weighted by each multiplier bit.
  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] m, input logic [W-1:0] q);
    logic [2*W-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++)
      if (q[i]) acc = acc + ({{W{1'b0}}, m} << i);
    return acc;
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] m, input logic [W-1:0] q, input bit inject);
    logic [2*W-1:0] res;
    @(negedge clk);
    check("R2 idle before start", {15'd0, busy_o}, 16'd0);
    mcand_i = m; mplier_i = q; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", {15'd0, busy_o}, 16'd1);
    check("R2 loaded product", product_o, {{W{1'b0}}, q});
    for (int i = 1; i < W; i++) begin
      if (inject && i == 2) begin
        start_i = 1'b1; mcand_i = W'($urandom); mplier_i = W'($urandom);
      end
      @(negedge clk);
      start_i = 1'b0;
      if (inject) begin mcand_i = W'($urandom); mplier_i = W'($urandom); end
      check("R3 busy during run", {14'd0, busy_o, done_o}, 16'd2);
    end
    @(negedge clk);
    check("R3 done at end", {14'd0, busy_o, done_o}, 16'd1);
    check(inject ? "R6 product with mid-run start" : "R4 product", product_o, ref_mul(m, q));
    res = product_o;
    mcand_i = ~m; mplier_i = ~q;
    @(negedge clk);
    check("R3 done single cycle", {15'd0, done_o}, 16'd0);
    @(negedge clk);
    check("R7 idle product held", product_o, res);
  endtask

  initial begin
    #(CLK_PER * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PER * 3);
    check("R1 reset outputs", {busy_o, done_o, product_o[2*W-3:0]}, 16'd0);
    check("R1 reset product", product_o, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_op(8'd13, 8'd11, 1'b0);
    check("R8 13x11", product_o, 16'd143);
    run_op(8'hFF, 8'hFF, 1'b0);
    check("R5 carry into MSB all-ones", product_o, 16'hFE01);
    run_op(8'h00, 8'hA7, 1'b0);
    run_op(8'hC3, 8'h00, 1'b0);
    run_op(8'h01, 8'hFF, 1'b0);
    run_op(8'h80, 8'h80, 1'b0);
    run_op(8'hFF, 8'h01, 1'b1);
    for (int n = 0; n < 40; n++)
      run_op(W'($urandom), W'($urandom), (n % 4) == 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule